// File: doc/BRIEF.md
# Pre-add multiply-accumulate slice

This block is a three-stage pipelined arithmetic slice. An operand formed from the low part of port A, optionally summed with port D, is multiplied as a signed number by port B. The 48-bit product, or the raw A and B bits joined side by side, then enters an add, subtract, AND or XOR unit. The second operand of that unit is either port C or the slice's own registered output, which is what lets it accumulate.

A pattern comparator watches the output register. It reports when the output equals a programmable value in all unmasked bits. When auto-clear is enabled, that match zeroes the output on the following clock. Two single-cycle flags mark an accumulation that steps past the masked all-ones value, or past the masked zero value on the way down.

A single clock enable advances or freezes the whole pipeline. The static controls (pattern, mask and auto-clear) act directly on the output stage. The per-operation controls travel down the pipeline with their data.

Top module: `mac_slice`

## Requirements
- R1: While `rst_n` is low, and on its release, `p`, `overflow` and `underflow` are zero.
- R2: When `preadd_en` is 1, the multiplier factor is (A[24:0] + D) truncated to 25 bits. When it is 0, the factor is A[24:0]. A[29:25] never reaches the multiplier.
- R3: The product is the signed 25x18 product of that factor and B, sign-extended to 48 bits.
- R4: With `ce` held high, a set of inputs that is held stable produces its result on `p` after the third rising clock edge.
- R5: While `ce` is low, no pipeline stage changes: `p` and the flags hold, and inputs applied during the stall are not captured.
- R6: `alu_op` 2'b00 gives Z + X, and 2'b01 gives Z - X. X is the multiplier path operand and Z is the second operand.
- R7: `alu_op` 2'b10 gives Z AND X, and 2'b11 gives Z XOR X. For these two codes X is {A, B}, with A in bits 47:18 and B in bits 17:0, whatever `mult_en` is.
- R8: When `mult_en` is 0, X is {A, B} for add and subtract as well.
- R9: `z_from_p` = 0 takes Z from C. `z_from_p` = 1 takes Z from the current `p`, so a held product accumulates once per enabled clock.
- R10: `match` is 1 exactly when `p` equals `pattern` in every bit where `mask` is 0. A mask bit of 1 means that bit is ignored. `match` follows `p` without extra delay.
- R11: When `autoreset_en` is 1 and `match` is 1 on an enabled clock edge, `p` becomes zero on that edge and both flags are cleared.
- R12: `overflow` rises together with a new `p` when an add accumulation (`z_from_p` = 1) leaves a `p` whose unmasked bits were all ones for one whose unmasked bits are not all ones.
- R13: `underflow` rises together with a new `p` when a subtract accumulation leaves a `p` whose unmasked bits were all zero for one whose unmasked bits are not all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for all stages |
| a | input | 30 | Operand A |
| b | input | 18 | Operand B, signed multiplier input |
| c | input | 48 | Operand C, direct second ALU operand |
| d | input | 25 | Operand D, pre-adder input |
| preadd_en | input | 1 | 1 = add D into the factor |
| mult_en | input | 1 | 1 = use the product, 0 = use {A, B} |
| alu_op | input | 2 | 00 add, 01 subtract, 10 AND, 11 XOR |
| z_from_p | input | 1 | 1 = second operand is p, 0 = C |
| pattern | input | 48 | Compare value for match |
| mask | input | 48 | 1 = bit ignored by the comparator |
| autoreset_en | input | 1 | 1 = a match clears p on the next edge |
| p | output | 48 | Registered result |
| match | output | 1 | Masked pattern equality of p |
| overflow | output | 1 | Accumulation stepped past masked all-ones |
| underflow | output | 1 | Accumulation stepped below masked zero |

## Verification
The bench builds the slice with its default widths: a 30-bit A, 18-bit B, 25-bit D and 48-bit result. At these widths the 25-bit pre-adder wrap into a negative factor can be reached, and so can sign extension of a 43-bit product into 48 bits. An 8-bit counter window is cut out with the mask, which brings both the overflow and the underflow boundary within a few clocks of a loaded start value. The same held product is accumulated across an auto-clear, so the cycle of the clear and the restart from zero are both observed.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_AND = 2'b10,
        ALU_XOR = 2'b11
    } alu_op_e;
endpackage

// File: rtl/mac_pattern_cmp.sv
module mac_pattern_cmp #(
    parameter int P_W = 48
) (
    input  logic [P_W-1:0] value,
    input  logic [P_W-1:0] ref_val,
    input  logic [P_W-1:0] mask,
    output logic           hit
);
    // A mask bit of 1 removes that bit from the comparison.
    always_comb begin
        hit = ~|((value ^ ref_val) & ~mask);
    end
endmodule

// File: rtl/mac_preadd_stage.sv
module mac_preadd_stage #(
    parameter int A_W = 30,
    parameter int B_W = 18,
    parameter int D_W = 25,
    parameter int P_W = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic [P_W-1:0] c,
    input  logic [D_W-1:0] d,
    input  logic           preadd_en,
    input  logic           mult_en,
    input  logic [1:0]     alu_op,
    input  logic           z_from_p,
    output logic [D_W-1:0] factor_q,
    output logic [A_W-1:0] a_q,
    output logic [B_W-1:0] b_q,
    output logic [P_W-1:0] c_q,
    output logic           mult_en_q,
    output logic [1:0]     op_q,
    output logic           zsel_q
);
    localparam int F_W = D_W;

    typedef struct packed {
        logic [F_W-1:0] factor;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic [P_W-1:0] c;
        logic           mult_en;
        logic [1:0]     op;
        logic           zsel;
    } s1_t;

    s1_t s1_d, s1_q;

    always_comb begin
        s1_d = s1_q;
        if (ce) begin
            s1_d.factor  = preadd_en ? (a[F_W-1:0] + d) : a[F_W-1:0];
            s1_d.a       = a;
            s1_d.b       = b;
            s1_d.c       = c;
            s1_d.mult_en = mult_en;
            s1_d.op      = alu_op;
            s1_d.zsel    = z_from_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign factor_q  = s1_q.factor;
    assign a_q       = s1_q.a;
    assign b_q       = s1_q.b;
    assign c_q       = s1_q.c;
    assign mult_en_q = s1_q.mult_en;
    assign op_q      = s1_q.op;
    assign zsel_q    = s1_q.zsel;

    assert_stage1_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(factor_q) && $stable(c_q) && $stable(op_q));
endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage #(
    parameter int A_W = 30,
    parameter int B_W = 18,
    parameter int D_W = 25,
    parameter int P_W = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic [D_W-1:0] factor,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic [P_W-1:0] c,
    input  logic           mult_en,
    input  logic [1:0]     op,
    input  logic           zsel,
    output logic [P_W-1:0] x_q,
    output logic [P_W-1:0] c_q,
    output logic [1:0]     op_q,
    output logic           zsel_q
);
    localparam int PR_W = D_W + B_W;
    localparam int EXT_W = P_W - PR_W;

    typedef struct packed {
        logic [P_W-1:0] x;
        logic [P_W-1:0] c;
        logic [1:0]     op;
        logic           zsel;
    } s2_t;

    s2_t s2_d, s2_q;
    logic signed [PR_W-1:0] prod;
    logic [P_W-1:0]         prod_ext;
    logic [P_W-1:0]         joined;

    always_comb begin
        prod     = $signed(factor) * $signed(b);
        prod_ext = {{EXT_W{prod[PR_W-1]}}, prod};
        joined   = {a, b};
        s2_d     = s2_q;
        if (ce) begin
            // Logic opcodes and the multiplier bypass both use the raw A:B word.
            s2_d.x    = (op[1] || !mult_en) ? joined : prod_ext;
            s2_d.c    = c;
            s2_d.op   = op;
            s2_d.zsel = zsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign x_q    = s2_q.x;
    assign c_q    = s2_q.c;
    assign op_q   = s2_q.op;
    assign zsel_q = s2_q.zsel;

    assert_stage2_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(x_q) && $stable(zsel_q));
endmodule

// File: rtl/mac_alu_stage.sv
module mac_alu_stage
    import mac_slice_pkg::*;
#(
    parameter int P_W = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic [P_W-1:0] x,
    input  logic [P_W-1:0] c,
    input  logic [1:0]     op,
    input  logic           zsel,
    input  logic [P_W-1:0] pattern,
    input  logic [P_W-1:0] mask,
    input  logic           autoreset_en,
    output logic [P_W-1:0] p_q,
    output logic           ovf_q,
    output logic           unf_q,
    output logic           match
);
    localparam int N_CMP    = 5;
    localparam int I_MATCH  = 0;
    localparam int I_ONES   = 1;
    localparam int I_ZEROS  = 2;
    localparam int I_ONES_N = 3;
    localparam int I_ZERO_N = 4;

    typedef struct packed {
        logic [P_W-1:0] p;
        logic           ovf;
        logic           unf;
    } s3_t;

    s3_t            s3_d, s3_q;
    alu_op_e        op_e;
    logic [P_W-1:0] z;
    logic [P_W-1:0] res;
    logic [P_W-1:0] cmp_val [N_CMP];
    logic [P_W-1:0] cmp_ref [N_CMP];
    logic [N_CMP-1:0] cmp_hit;

    always_comb begin
        op_e = alu_op_e'(op);
        z    = zsel ? s3_q.p : c;
        unique case (op_e)
            ALU_ADD: res = z + x;
            ALU_SUB: res = z - x;
            ALU_AND: res = z & x;
            default: res = z ^ x;
        endcase
    end

    always_comb begin
        cmp_val[I_MATCH]  = s3_q.p;  cmp_ref[I_MATCH]  = pattern;
        cmp_val[I_ONES]   = s3_q.p;  cmp_ref[I_ONES]   = '1;
        cmp_val[I_ZEROS]  = s3_q.p;  cmp_ref[I_ZEROS]  = '0;
        cmp_val[I_ONES_N] = res;     cmp_ref[I_ONES_N] = '1;
        cmp_val[I_ZERO_N] = res;     cmp_ref[I_ZERO_N] = '0;
    end

    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
        mac_pattern_cmp #(.P_W(P_W)) cmp_i (
            .value  (cmp_val[gi]),
            .ref_val(cmp_ref[gi]),
            .mask   (mask),
            .hit    (cmp_hit[gi])
        );
    end

    always_comb begin
        s3_d = s3_q;
        if (ce) begin
            if (autoreset_en && cmp_hit[I_MATCH]) begin
                s3_d = '0;
            end else begin
                s3_d.p   = res;
                s3_d.ovf = zsel && (op_e == ALU_ADD) && cmp_hit[I_ONES] && !cmp_hit[I_ONES_N];
                s3_d.unf = zsel && (op_e == ALU_SUB) && cmp_hit[I_ZEROS] && !cmp_hit[I_ZERO_N];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

    assign p_q   = s3_q.p;
    assign ovf_q = s3_q.ovf;
    assign unf_q = s3_q.unf;
    assign match = cmp_hit[I_MATCH];

    assert_autoreset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && autoreset_en && match) |=> (p_q == '0) && !ovf_q && !unf_q);
    assert_output_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(p_q) && $stable(ovf_q) && $stable(unf_q));
    assert_overflow_only_add_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && (op != 2'b00)) |=> !ovf_q);
    assert_underflow_only_sub_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && (op != 2'b01)) |=> !unf_q);
    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && unf_q));
endmodule

// File: rtl/mac_slice.sv
module mac_slice #(
    parameter int A_W = 30,
    parameter int B_W = 18,
    parameter int D_W = 25,
    parameter int P_W = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic [P_W-1:0] c,
    input  logic [D_W-1:0] d,
    input  logic           preadd_en,
    input  logic           mult_en,
    input  logic [1:0]     alu_op,
    input  logic           z_from_p,
    input  logic [P_W-1:0] pattern,
    input  logic [P_W-1:0] mask,
    input  logic           autoreset_en,
    output logic [P_W-1:0] p,
    output logic           match,
    output logic           overflow,
    output logic           underflow
);
    logic [D_W-1:0] s1_factor;
    logic [A_W-1:0] s1_a;
    logic [B_W-1:0] s1_b;
    logic [P_W-1:0] s1_c;
    logic           s1_mult_en;
    logic [1:0]     s1_op;
    logic           s1_zsel;
    logic [P_W-1:0] s2_x;
    logic [P_W-1:0] s2_c;
    logic [1:0]     s2_op;
    logic           s2_zsel;

    mac_preadd_stage #(.A_W(A_W), .B_W(B_W), .D_W(D_W), .P_W(P_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .a(a), .b(b), .c(c), .d(d),
        .preadd_en(preadd_en), .mult_en(mult_en), .alu_op(alu_op), .z_from_p(z_from_p),
        .factor_q(s1_factor), .a_q(s1_a), .b_q(s1_b), .c_q(s1_c),
        .mult_en_q(s1_mult_en), .op_q(s1_op), .zsel_q(s1_zsel)
    );

    mac_mult_stage #(.A_W(A_W), .B_W(B_W), .D_W(D_W), .P_W(P_W)) mul_i (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .factor(s1_factor), .a(s1_a), .b(s1_b), .c(s1_c),
        .mult_en(s1_mult_en), .op(s1_op), .zsel(s1_zsel),
        .x_q(s2_x), .c_q(s2_c), .op_q(s2_op), .zsel_q(s2_zsel)
    );

    mac_alu_stage #(.P_W(P_W)) alu_i (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .x(s2_x), .c(s2_c), .op(s2_op), .zsel(s2_zsel),
        .pattern(pattern), .mask(mask), .autoreset_en(autoreset_en),
        .p_q(p), .ovf_q(overflow), .unf_q(underflow), .match(match)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (p == '0) || rst_n);
endmodule

// File: tb/mac_slice_tb_top.sv
module mac_slice_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b1;
    logic [29:0] a = '0;
    logic [17:0] b = '0;
    logic [47:0] c = '0;
    logic [24:0] d = '0;
    logic        preadd_en = 1'b0;
    logic        mult_en = 1'b1;
    logic [1:0]  alu_op = 2'b00;
    logic        z_from_p = 1'b0;
    logic [47:0] pattern = '0;
    logic [47:0] mask = '1;
    logic        autoreset_en = 1'b0;
    logic [47:0] p;
    logic        match, overflow, underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_slice dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .a(a), .b(b), .c(c), .d(d),
        .preadd_en(preadd_en), .mult_en(mult_en), .alu_op(alu_op), .z_from_p(z_from_p),
        .pattern(pattern), .mask(mask), .autoreset_en(autoreset_en),
        .p(p), .match(match), .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input string what, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setin(input logic [29:0] ia, input logic [17:0] ib, input logic [47:0] ic,
                         input logic [24:0] id, input logic ipre, input logic imul,
                         input logic [1:0] iop, input logic izp);
        a = ia; b = ib; c = ic; d = id;
        preadd_en = ipre; mult_en = imul; alu_op = iop; z_from_p = izp;
    endtask

    task automatic load_p(input logic [47:0] v);
        setin(30'd0, 18'd0, v, 25'd0, 1'b0, 1'b1, 2'b00, 1'b0);
        step(3);
    endtask

    task automatic t_reset();
        chk("R1", "p in reset", p, 48'd0);
        chk("R1", "flags in reset", {46'd0, overflow, underflow}, 48'd0);
        @(negedge clk); rst_n = 1'b1;
        step(1);
        chk("R1", "p after release", p, 48'd0);
    endtask

    task automatic t_signed_mult();
        setin(30'h3FFFFFFD, 18'd7, 48'd0, 25'd0, 1'b0, 1'b1, 2'b00, 1'b0);
        step(2);
        chk("R4", "not yet after two edges", p, 48'd0);
        step(1);
        chk("R3", "-3*7 sign extended", p, 48'hFFFF_FFFF_FFEB);
        setin(30'h3E000005, 18'd3, 48'd0, 25'd0, 1'b0, 1'b1, 2'b00, 1'b0);
        step(3);
        chk("R2", "A upper bits ignored", p, 48'd15);
    endtask

    task automatic t_preadd();
        setin(30'd100, 18'h3FFFE, 48'd0, 25'h1FFFFE2, 1'b1, 1'b1, 2'b00, 1'b0);
        step(3);
        chk("R2", "(100-30)*-2", p, 48'hFFFF_FFFF_FF74);
        setin(30'h0FFFFFF, 18'd1, 48'd0, 25'd1, 1'b1, 1'b1, 2'b00, 1'b0);
        step(3);
        chk("R2", "25-bit pre-add wrap", p, 48'hFFFF_FF00_0000);
    endtask

    task automatic t_sub();
        setin(30'd7, 18'd3, 48'd100, 25'd0, 1'b0, 1'b1, 2'b01, 1'b0);
        step(3);
        chk("R6", "C minus product", p, 48'd79);
        setin(30'd7, 18'd3, 48'd100, 25'd0, 1'b0, 1'b1, 2'b00, 1'b0);
        step(3);
        chk("R6", "C plus product", p, 48'd121);
    endtask

    task automatic t_logic();
        setin(30'h15555555, 18'h3FFFF, 48'hFFFF_0000_FFFF, 25'd0, 1'b0, 1'b1, 2'b10, 1'b0);
        step(3);
        chk("R7", "AND with A:B", p, 48'hFFFF_0000_FFFF & {30'h15555555, 18'h3FFFF});
        setin(30'h15555555, 18'h3FFFF, 48'hFFFF_0000_FFFF, 25'd0, 1'b0, 1'b1, 2'b11, 1'b0);
        step(3);
        chk("R7", "XOR with A:B", p, 48'hFFFF_0000_FFFF ^ {30'h15555555, 18'h3FFFF});
    endtask

    task automatic t_bypass();
        setin(30'd1, 18'd2, 48'd10, 25'd0, 1'b0, 1'b0, 2'b00, 1'b0);
        step(3);
        chk("R8", "multiplier bypass add", p, 48'h4000C);
    endtask

    task automatic t_stall();
        load_p(48'd7);
        ce = 1'b0;
        setin(30'd0, 18'd0, 48'd99, 25'd0, 1'b0, 1'b1, 2'b00, 1'b0);
        step(5);
        chk("R5", "p held while stalled", p, 48'd7);
        ce = 1'b1;
        step(2);
        chk("R5", "stall kept old stages", p, 48'd7);
        step(1);
        chk("R5", "resumes after stall", p, 48'd99);
    endtask

    task automatic t_accum();
        load_p(48'd0);
        setin(30'd5, 18'd3, 48'd1000, 25'd0, 1'b0, 1'b1, 2'b00, 1'b1);
        step(3);
        chk("R9", "first accumulation", p, 48'd15);
        step(1);
        chk("R9", "second accumulation", p, 48'd30);
        step(2);
        chk("R9", "fourth accumulation", p, 48'd60);
    endtask

    task automatic t_match();
        load_p(48'h1234_5678_9ABC);
        pattern = 48'h1234_0000_0000; mask = 48'h0000_FFFF_FFFF;
        #1;
        chk("R10", "masked match", {47'd0, match}, 48'd1);
        pattern = 48'h1235_0000_0000;
        #1;
        chk("R10", "masked mismatch", {47'd0, match}, 48'd0);
        pattern = 48'h1234_5678_9ABC; mask = 48'd0;
        #1;
        chk("R10", "exact match", {47'd0, match}, 48'd1);
        pattern = '0; mask = '1;
    endtask

    task automatic t_autoreset();
        load_p(48'd0);
        pattern = 48'd45; mask = 48'd0; autoreset_en = 1'b1;
        setin(30'd5, 18'd3, 48'd0, 25'd0, 1'b0, 1'b1, 2'b00, 1'b1);
        step(5);
        chk("R11", "reaches pattern", p, 48'd45);
        chk("R10", "match at pattern", {47'd0, match}, 48'd1);
        step(1);
        chk("R11", "cleared after match", p, 48'd0);
        step(1);
        chk("R11", "restarts from zero", p, 48'd15);
        autoreset_en = 1'b0; pattern = '0; mask = '1;
    endtask

    task automatic t_overflow();
        mask = ~48'hFF;
        load_p(48'hFD);
        setin(30'd1, 18'd1, 48'd0, 25'd0, 1'b0, 1'b1, 2'b00, 1'b1);
        step(4);
        chk("R12", "at all ones", p, 48'hFF);
        chk("R12", "no overflow yet", {47'd0, overflow}, 48'd0);
        step(1);
        chk("R12", "past all ones", p, 48'h100);
        chk("R12", "overflow pulse", {47'd0, overflow}, 48'd1);
        step(1);
        chk("R12", "overflow single cycle", {47'd0, overflow}, 48'd0);
        mask = '1;
    endtask

    task automatic t_underflow();
        mask = ~48'hFF;
        load_p(48'd2);
        setin(30'd1, 18'd1, 48'd0, 25'd0, 1'b0, 1'b1, 2'b01, 1'b1);
        step(4);
        chk("R13", "at zero", p, 48'd0);
        chk("R13", "no underflow yet", {47'd0, underflow}, 48'd0);
        step(1);
        chk("R13", "below zero", p, 48'hFFFF_FFFF_FFFF);
        chk("R13", "underflow pulse", {46'd0, overflow, underflow}, 48'd1);
        mask = '1;
    endtask

    initial begin
        step(3);
        t_reset();
        t_signed_mult();
        t_preadd();
        t_sub();
        t_logic();
        t_bypass();
        t_stall();
        t_accum();
        t_match();
        t_autoreset();
        t_overflow();
        t_underflow();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule